// File: doc/BRIEF.md
# Single-Wire Bus Reset and Presence Detector

This block issues the reset pulse that opens every transaction on a single-wire open-drain bus and then decides what the bus did in answer. It can report that no slave answered, that a slave gave a valid presence pulse, or that the bus is shorted. A controller raises a start strobe together with a speed select (standard or overdrive). The block pulls the bus low through an active-low drive enable, releases it, samples the bus level once per microsecond, and raises a one-cycle done strobe with a two-bit result once the full reset slot has elapsed.

A short and a presence pulse both pull the bus low. The block tells them apart by how long the bus stays low. A presence pulse never lasts more than 240 µs at standard speed (24 µs at overdrive), so a longer low run is a short. The bus is also checked once before the reset is driven, and a bus that is already low ends the request at once as a short. A speed-mode flag records whether the slaves can be assumed to be in overdrive. A reset at standard speed clears it, an overdrive reset sets it, and any short clears it, because a short or a loss of contact returns every slave to standard speed.

The microsecond timebase is a clock-enable counter that restarts with each accepted reset. All slot timing is therefore an exact multiple of the clock count per microsecond.

Top module: `bus_reset_detector`

## Requirements
- R1: After reset the drive enable is high (bus released), done is low, the result is 2'b00 and the speed flag is 0.
- R2: An accepted start holds the drive enable low for exactly 480 µs at standard speed or 48 µs at overdrive, counted from the start edge, and then releases it. While no slot is running the drive enable stays high.
- R3: Done pulses for exactly one clock. Its rising edge comes 960 µs (standard) or 96 µs (overdrive) after the clock edge that accepted the start, and the result output is valid from that cycle. The result is encoded as 2'b00 no device, 2'b01 presence, 2'b10 short.
- R4: If the bus is low in the cycle in which start is seen, no reset is driven. Done pulses in the next cycle with result 2'b10.
- R5: A low sample taken at µs k after release, with 70 ≤ k < 240 (standard) or 8 ≤ k < 24 (overdrive), gives result 2'b01, unless R6 applies.
- R6: A run of more than 240 (standard) or 24 (overdrive) consecutive low samples after release gives result 2'b10, whether or not a presence pulse was also seen. A run of exactly that length is not a short.
- R7: If no low sample falls in the presence window and no run is too long, the result is 2'b00. This includes low pulses that lie wholly before or after the window.
- R8: A start strobe, with either speed select, has no effect while a slot is running. It does not alter the slot length, does not cause a second done, and does not change the speed flag.
- R9: The speed flag takes the requested speed (1 = overdrive) on the clock edge that accepts a start.
- R10: A short result, from either R4 or R6, clears the speed flag in the same cycle that done is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a reset slot (single-cycle strobe) |
| od_req_i | input | 1 | Speed for the requested slot: 1 = overdrive, 0 = standard |
| bus_i | input | 1 | Synchronized bus level, 1 = high |
| drive_n_o | output | 1 | Active-low drive enable; 0 pulls the bus low |
| done_o | output | 1 | One-cycle strobe at the end of a slot or of a refused start |
| result_o | output | 2 | Slot outcome: 00 none, 01 presence, 10 short |
| speed_od_o | output | 1 | Speed flag: 1 = slaves assumed in overdrive |

## Verification
The bench sweeps a low pulse of several lengths across every microsecond of the overdrive reply period. It also aims a set of standard-speed pulses at the exact window edges (69/70, 239/240) and at the short threshold (240 versus 241 µs of low). A design with an off-by-one window edge or run compare would misclassify those single-microsecond pulses, or would call a maximum-length presence a short. A bus that is already low at the start checks that no reset is driven and that the speed flag falls. A second start issued mid-slot with the other speed would, in a careless design, restart the timer or flip the speed flag, and the bench would see that in the slot length or in the flag.

// File: rtl/bprd_pkg.sv
// Package: shared result and state types for the bus reset / presence detector.
// Assumes: result codes are decoded by the command sequencer outside this block.
package bprd_pkg;

    typedef enum logic [1:0] {
        RES_NONE    = 2'b00,
        RES_PRESENT = 2'b01,
        RES_SHORT   = 2'b10
    } reset_result_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } slot_state_e;

endpackage

// File: rtl/bprd_tick_gen.sv
// Module: microsecond clock-enable generator.
// Produces a one-cycle tick every CLK_PER_US clocks while running. The count
// restarts on 'restart', so the first tick lands exactly CLK_PER_US clocks
// after the restart edge.
// Assumes: CLK_PER_US >= 1.
module bprd_tick_gen #(
    parameter int CLK_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic running,
    output logic tick
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] presc_q;

    // Prescaler: wraps at LAST while running, zeroed on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else if (restart) begin
            presc_q <= '0;
        end else if (running) begin
            presc_q <= (presc_q == LAST) ? '0 : presc_q + 1'b1;
        end
    end

    assign tick = running && (presc_q == LAST);

    generate
        if (CLK_PER_US > 1) begin : g_gap_check
            // Ticks are never back to back when a microsecond spans several clocks.
            assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/bprd_phase_timer.sv
// Module: slot phase timer.
// Latches the speed at launch, counts elapsed microseconds, and derives the
// drive-low phase, the per-microsecond sample strobe after release, the index
// of that sample and the end-of-slot strobe. It also selects the presence
// window and the short threshold for the latched speed.
// Assumes: all overdrive values are no larger than the standard ones, and each
// LOW value is below its TOTAL value.
module bprd_phase_timer #(
    parameter int STD_LOW_US   = 480,
    parameter int STD_WIN_LO   = 70,
    parameter int STD_WIN_HI   = 240,
    parameter int STD_LOW_MAX  = 240,
    parameter int STD_TOTAL_US = 960,
    parameter int OD_LOW_US    = 48,
    parameter int OD_WIN_LO    = 8,
    parameter int OD_WIN_HI    = 24,
    parameter int OD_LOW_MAX   = 24,
    parameter int OD_TOTAL_US  = 96,
    localparam int UW = $clog2(STD_TOTAL_US + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          od_in,
    input  logic          running,
    input  logic          tick,
    output logic          drive_low,
    output logic          sample_en,
    output logic [UW-1:0] since_rel,
    output logic [UW-1:0] win_lo,
    output logic [UW-1:0] win_hi,
    output logic [UW-1:0] low_max,
    output logic          slot_end
);
    logic          od_q;
    logic [UW-1:0] us_q;
    logic [UW-1:0] low_sel;
    logic [UW-1:0] total_sel;

    // Speed latch: holds the speed of the slot in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            od_q <= 1'b0;
        end else if (launch) begin
            od_q <= od_in;
        end
    end

    // Microsecond counter: cleared on launch, advanced on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            us_q <= '0;
        end else if (launch) begin
            us_q <= '0;
        end else if (running && tick) begin
            us_q <= us_q + 1'b1;
        end
    end

    // Timing selection for the latched speed.
    always_comb begin
        if (od_q) begin
            low_sel   = UW'(OD_LOW_US);
            total_sel = UW'(OD_TOTAL_US);
            win_lo    = UW'(OD_WIN_LO);
            win_hi    = UW'(OD_WIN_HI);
            low_max   = UW'(OD_LOW_MAX);
        end else begin
            low_sel   = UW'(STD_LOW_US);
            total_sel = UW'(STD_TOTAL_US);
            win_lo    = UW'(STD_WIN_LO);
            win_hi    = UW'(STD_WIN_HI);
            low_max   = UW'(STD_LOW_MAX);
        end
    end

    assign drive_low = running && (us_q < low_sel);
    assign sample_en = running && tick && (us_q >= low_sel);
    assign since_rel = us_q - low_sel;
    assign slot_end  = running && tick && (us_q == total_sel - 1'b1);

    // The counter never passes the slot length while a slot runs.
    assert_us_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (us_q < total_sel));

endmodule

// File: rtl/bprd_presence_eval.sv
// Module: presence / short classifier.
// On each sample strobe after release it records whether a low sample fell in
// the presence window, and tracks the current run of consecutive low samples.
// A run longer than the threshold marks a short, which outranks presence.
// The verdict output includes the sample taken in the current cycle.
// Assumes: sample_en only pulses after release; 'clear' comes at launch.
module bprd_presence_eval #(
    parameter int UW = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   sample_en,
    input  logic                   bus_level,
    input  logic [UW-1:0]          since_rel,
    input  logic [UW-1:0]          win_lo,
    input  logic [UW-1:0]          win_hi,
    input  logic [UW-1:0]          low_max,
    output bprd_pkg::reset_result_e verdict
);
    import bprd_pkg::*;

    localparam logic [UW-1:0] RUN_SAT = '1;

    logic          pres_q, pres_d;
    logic          short_q, short_d;
    logic [UW-1:0] run_q, run_d;
    logic          low_now;
    logic          in_window;

    assign low_now   = sample_en && !bus_level;
    assign in_window = (since_rel >= win_lo) && (since_rel < win_hi);

    // Next-state flags and low-run length for the current sample.
    always_comb begin
        pres_d  = pres_q;
        short_d = short_q;
        run_d   = run_q;
        if (sample_en) begin
            if (low_now) begin
                run_d = (run_q == RUN_SAT) ? run_q : run_q + 1'b1;
                if (in_window) pres_d = 1'b1;
                if (run_q >= low_max) short_d = 1'b1;
            end else begin
                run_d = '0;
            end
        end
    end

    // Classifier state: cleared at launch, otherwise follows the sample logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q  <= 1'b0;
            short_q <= 1'b0;
            run_q   <= '0;
        end else if (clear) begin
            pres_q  <= 1'b0;
            short_q <= 1'b0;
            run_q   <= '0;
        end else begin
            pres_q  <= pres_d;
            short_q <= short_d;
            run_q   <= run_d;
        end
    end

    // Verdict: short outranks presence.
    always_comb begin
        if (short_d)     verdict = RES_SHORT;
        else if (pres_d) verdict = RES_PRESENT;
        else             verdict = RES_NONE;
    end

    // Once seen in a slot, a short stays seen until the next launch.
    assert_short_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (short_q && !clear) |=> short_q);

endmodule

// File: rtl/bprd_speed_mode.sv
// Module: bus speed flag.
// Follows the speed of each accepted reset and falls back to standard
// speed whenever a short is reported.
// Assumes: 'accept' and 'short_seen' are never high in the same cycle.
module bprd_speed_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic od_req,
    input  logic short_seen,
    output logic speed_od
);
    // Speed flag update: a short wins; otherwise an accepted start sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_od <= 1'b0;
        end else if (short_seen) begin
            speed_od <= 1'b0;
        end else if (accept) begin
            speed_od <= od_req;
        end
    end

endmodule

// File: rtl/bus_reset_detector.sv
// Module: bus reset and presence detector (top).
// Checks the bus before the reset, runs one reset slot per accepted start,
// and registers done, result and the speed flag. Starts that arrive while a
// slot is running are dropped.
// Assumes: bus_i is already synchronized to clk; drive_n_o low means the
// external open-drain driver pulls the bus low.
module bus_reset_detector #(
    parameter int CLK_PER_US   = 125,
    parameter int STD_LOW_US   = 480,
    parameter int STD_WIN_LO   = 70,
    parameter int STD_WIN_HI   = 240,
    parameter int STD_LOW_MAX  = 240,
    parameter int STD_TOTAL_US = 960,
    parameter int OD_LOW_US    = 48,
    parameter int OD_WIN_LO    = 8,
    parameter int OD_WIN_HI    = 24,
    parameter int OD_LOW_MAX   = 24,
    parameter int OD_TOTAL_US  = 96
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       od_req_i,
    input  logic       bus_i,
    output logic       drive_n_o,
    output logic       done_o,
    output logic [1:0] result_o,
    output logic       speed_od_o
);
    import bprd_pkg::*;

    localparam int UW = $clog2(STD_TOTAL_US + 1);

    slot_state_e   st_q;
    logic          launch;
    logic          refuse_short;
    logic          running;
    logic          tick;
    logic          drive_low;
    logic          sample_en;
    logic          slot_end;
    logic [UW-1:0] since_rel;
    logic [UW-1:0] win_lo;
    logic [UW-1:0] win_hi;
    logic [UW-1:0] low_max;
    reset_result_e verdict;
    logic          done_q;
    reset_result_e result_q;
    logic          short_seen;

    assign running      = (st_q == ST_BUSY);
    assign launch       = (st_q == ST_IDLE) && start_i && bus_i;
    assign refuse_short = (st_q == ST_IDLE) && start_i && !bus_i;
    assign short_seen   = refuse_short || (slot_end && (verdict == RES_SHORT));

    // Slot state: idle until a clean start, busy until the slot ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else if (launch) begin
            st_q <= ST_BUSY;
        end else if (slot_end) begin
            st_q <= ST_IDLE;
        end
    end

    // Done strobe and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= RES_NONE;
        end else begin
            done_q <= refuse_short || slot_end;
            if (refuse_short) begin
                result_q <= RES_SHORT;
            end else if (slot_end) begin
                result_q <= verdict;
            end
        end
    end

    bprd_tick_gen #(
        .CLK_PER_US (CLK_PER_US)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch),
        .running (running),
        .tick    (tick)
    );

    bprd_phase_timer #(
        .STD_LOW_US   (STD_LOW_US),
        .STD_WIN_LO   (STD_WIN_LO),
        .STD_WIN_HI   (STD_WIN_HI),
        .STD_LOW_MAX  (STD_LOW_MAX),
        .STD_TOTAL_US (STD_TOTAL_US),
        .OD_LOW_US    (OD_LOW_US),
        .OD_WIN_LO    (OD_WIN_LO),
        .OD_WIN_HI    (OD_WIN_HI),
        .OD_LOW_MAX   (OD_LOW_MAX),
        .OD_TOTAL_US  (OD_TOTAL_US)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .od_in     (od_req_i),
        .running   (running),
        .tick      (tick),
        .drive_low (drive_low),
        .sample_en (sample_en),
        .since_rel (since_rel),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .low_max   (low_max),
        .slot_end  (slot_end)
    );

    bprd_presence_eval #(
        .UW (UW)
    ) u_eval (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (launch),
        .sample_en (sample_en),
        .bus_level (bus_i),
        .since_rel (since_rel),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .low_max   (low_max),
        .verdict   (verdict)
    );

    bprd_speed_mode u_speed (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (launch),
        .od_req     (od_req_i),
        .short_seen (short_seen),
        .speed_od   (speed_od_o)
    );

    assign drive_n_o = !drive_low;
    assign done_o    = done_q;
    assign result_o  = result_q;

    // Done is a single-cycle strobe.
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // A start on a low bus drives nothing and reports a short next cycle.
    assert_precheck_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && start_i && !bus_i) |=>
            (done_o && (result_o == 2'b10) && drive_n_o));

    // The bus is never driven outside a running slot.
    assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> drive_n_o);

    // A running slot is only left through its end strobe, whatever start does.
    assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !slot_end) |=> running);

    // A short report always comes with standard speed.
    assert_short_clears_speed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (result_o == 2'b10)) |-> !speed_od_o);

endmodule

// File: tb/bus_reset_detector_tb.sv
// Bench: sweeps slave low pulses across the reply period at both speeds and
// checks slot timing, classification, refusal and the speed flag.
module bus_reset_detector_tb;

    localparam int C = 2;
    localparam int S_LOW = 480, S_LO = 70, S_HI = 240, S_MAX = 240, S_TOT = 960;
    localparam int O_LOW = 48,  O_LO = 8,  O_HI = 24,  O_MAX = 24,  O_TOT = 96;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       od_req_i = 1'b0;
    logic       drive_n_o;
    logic       done_o;
    logic [1:0] result_o;
    logic       speed_od_o;
    logic       slave_low = 1'b0;
    logic       stuck = 1'b0;
    logic       bus_i;

    int n_chk = 0;
    int n_bad = 0;
    int pa = 0;
    int pb = 0;

    always #4 clk = ~clk;

    assign bus_i = drive_n_o & ~slave_low & ~stuck;

    bus_reset_detector #(.CLK_PER_US(C)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .od_req_i   (od_req_i),
        .bus_i      (bus_i),
        .drive_n_o  (drive_n_o),
        .done_o     (done_o),
        .result_o   (result_o),
        .speed_od_o (speed_od_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Slave model: holds the bus low from pa to pb microseconds after release.
    initial begin
        int  m;
        bit  rel;
        logic prev;
        m = 0;
        rel = 1'b0;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (drive_n_o == 1'b0) begin
                rel = 1'b0;
                slave_low = 1'b0;
            end else begin
                if (prev == 1'b0) begin
                    rel = 1'b1;
                    m = 0;
                end else if (rel) begin
                    m++;
                end
                slave_low = rel && (m >= pa * C) && (m < pb * C);
            end
            prev = drive_n_o;
        end
    end

    // One full slot with a slave low pulse [a,b) us after release.
    task automatic run_slot(input bit od, input int a, input int b, input bit retrig);
        int lowus, tot, lo, hi, mx, w, run, expr, n, lows, got;
        bit pres, sh, seen;
        lowus = od ? O_LOW : S_LOW;
        tot   = od ? O_TOT : S_TOT;
        lo    = od ? O_LO  : S_LO;
        hi    = od ? O_HI  : S_HI;
        mx    = od ? O_MAX : S_MAX;
        w     = tot - lowus;
        pres  = (a < b) && (a < hi) && (b > lo);
        run   = (a < b && a < w) ? (((b < w) ? b : w) - a) : 0;
        sh    = run > mx;
        expr  = sh ? 2 : (pres ? 1 : 0);
        @(negedge clk);
        pa = a;
        pb = b;
        start_i = 1'b1;
        od_req_i = od;
        n = 0;
        lows = 0;
        got = 0;
        seen = 1'b0;
        while (!seen && n < 3000) begin
            @(negedge clk);
            start_i = 1'b0;
            n++;
            if (drive_n_o == 1'b0) lows++;
            if (n == 2) check(speed_od_o == od, "R9 speed on accept", speed_od_o, od);
            if (retrig && n == 5) begin
                start_i = 1'b1;
                od_req_i = ~od;
            end
            if (retrig && n == 7)
                check(speed_od_o == od, "R8 speed kept on ignored start", speed_od_o, od);
            if (done_o) begin
                seen = 1'b1;
                got = result_o;
            end
        end
        check(n == tot * C + 1, "R3 done time", n, tot * C + 1);
        check(lows == lowus * C, "R2 low duration", lows, lowus * C);
        if (sh)        check(got == expr, "R6 short class", got, expr);
        else if (pres) check(got == expr, "R5 presence class", got, expr);
        else           check(got == expr, "R7 no-device class", got, expr);
        if (sh) check(speed_od_o == 1'b0, "R10 short clears speed", speed_od_o, 0);
        else    check(speed_od_o == od, "R9 speed held", speed_od_o, od);
        @(negedge clk);
        check(done_o == 1'b0, "R3 single pulse", done_o, 0);
        if (retrig) begin
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (done_o || !drive_n_o) begin
                    check(1'b0, "R8 no second slot", 1, 0);
                    break;
                end
            end
        end
        pa = 0;
        pb = 0;
    endtask

    // Start on a bus that is already low.
    task automatic refused_start(input bit od);
        @(negedge clk);
        stuck = 1'b1;
        start_i = 1'b1;
        od_req_i = od;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b1, "R4 done next cycle", done_o, 1);
        check(result_o == 2'b10, "R4 short result", result_o, 2);
        check(drive_n_o == 1'b1, "R4 no drive", drive_n_o, 1);
        check(speed_od_o == 1'b0, "R10 refused short clears speed", speed_od_o, 0);
        stuck = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0, "R4 single pulse", done_o, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lens[6];
        lens = '{1, 3, 16, 24, 25, 40};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(drive_n_o == 1'b1, "R1 drive idle", drive_n_o, 1);
        check(done_o == 1'b0, "R1 done low", done_o, 0);
        check(result_o == 2'b00, "R1 result", result_o, 0);
        check(speed_od_o == 1'b0, "R1 speed", speed_od_o, 0);

        // Standard-speed boundary cases.
        run_slot(1'b0, 0, 0, 1'b0);
        run_slot(1'b0, 69, 70, 1'b0);
        run_slot(1'b0, 70, 71, 1'b0);
        run_slot(1'b0, 239, 240, 1'b0);
        run_slot(1'b0, 240, 241, 1'b0);
        run_slot(1'b0, 10, 250, 1'b0);
        run_slot(1'b0, 10, 251, 1'b0);
        run_slot(1'b0, 0, 480, 1'b0);
        run_slot(1'b0, 30, 150, 1'b1);

        // Overdrive sweep of pulse position and length.
        for (int a = 0; a < O_TOT - O_LOW; a++) begin
            for (int j = 0; j < 6; j++) begin
                run_slot(1'b1, a, a + lens[j], 1'b0);
            end
        end
        run_slot(1'b1, 10, 20, 1'b1);

        // Refused starts, after leaving overdrive set.
        refused_start(1'b1);
        run_slot(1'b1, 9, 12, 1'b0);
        refused_start(1'b0);

        finish_run();
    end

endmodule